// File: doc/BRIEF.md
# AES-256 Iterative Block Encryptor

This block turns one 128-bit plaintext block into ciphertext under a 256-bit key. It performs one cipher round per clock. The round keys are not stored inside the block. The engine drives the index of the round key it needs, and the surrounding logic returns that 128-bit key on a separate input in the same cycle. A typical source for the keys is a small key-schedule memory or a key-expansion unit elsewhere on the chip.

A single-cycle start pulse loads the plaintext and the engine becomes busy. The start cycle combines the plaintext with round key 0 before any round runs. After that, rounds 1 to 14 each do the same four steps in order:

1. byte substitution
2. row rotation
3. column mixing (skipped in round 14)
4. XOR with the round key

When the last round is done, the ciphertext is held at the output and a one-cycle done pulse marks it as valid.

Top module: `aes256_round_engine`

## Requirements
- R1: Whenever the engine is in reset or idle, `done_o` is 0 and `rk_idx_o` is 0. After reset the engine is idle.
- R2: In the cycle a start is accepted, the key presented at index 0 is XORed with the plaintext. In the following consecutive cycles `rk_idx_o` steps through 1, 2, … 14, one step per cycle.
- R3: The output `ct_o` equals the AES-256 encryption of `pt_i` under the supplied round keys. Byte k of a block is bits [127-8k -: 8], and byte k sits at row k mod 4, column k div 4. Row r is rotated left by r byte positions.
- R4: `done_o` is high in exactly the 15th cycle after the clock edge that accepts start, and only for that one cycle. `ct_o` is valid in that cycle and stays unchanged until the next accepted start.
- R5: While the engine is busy, `start_i` and `pt_i` have no effect on the index sequence, the latency or the result.
- R6: Rounds 1 to 13 apply column mixing over GF(2^8) with reduction polynomial 0x11B. Round 14 does not apply it.
- R7: A start asserted in the cycle that `done_o` is high is accepted, so blocks can run back to back with no idle cycle.
- R8: With key 000102…1e1f and plaintext 00112233445566778899aabbccddeeff, the ciphertext is 8ea2b7ca516745bfeafc49904b496089.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse. Sampled only while the engine is idle |
| pt_i | input | 128 | Plaintext block, byte 0 in the top bits |
| rk_i | input | 128 | Round key selected by `rk_idx_o`, valid in the same cycle |
| rk_idx_o | output | 4 | Index of the round key requested this cycle |
| ct_o | output | 128 | Ciphertext block |
| done_o | output | 1 | One-cycle pulse: `ct_o` is valid |

## Verification
The done pulse of one block and the start of the next can fall in the same cycle. In that cycle the engine leaves its last round and must also accept a new plaintext with key index 0. The bench provokes this by issuing the next start in the very cycle it observes done. It then judges the new block on three points: a full 15-cycle latency, a clean index sequence from 1, and a ciphertext that matches a reference model in the bench. Other runs toggle start and scramble the plaintext throughout the busy window, and their results must be identical to those of quiet runs.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

    localparam int BLK_W  = 128;
    localparam int BYTE_W = 8;
    localparam int NBYTES = BLK_W / BYTE_W;

    // Multiply by x in GF(2^8), polynomial 0x11B
    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] aa;
        p  = 8'h00;
        aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ aa;
            aa = xt(aa);
        end
        return p;
    endfunction

    // Substitution: inverse as x^254, then affine map
    function automatic logic [7:0] sbox(input logic [7:0] x);
        logic [7:0] sq;
        logic [7:0] inv;
        sq  = x;
        inv = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_sub_shift.sv
module aes_sub_shift
    import aes_rnd_pkg::*;
(
    input  logic [BLK_W-1:0] st_i,
    output logic [BLK_W-1:0] st_o
);
    // Output byte at (row, col) takes substituted input byte at (row, col+row)
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam int ROW = i % 4;
        localparam int COL = i / 4;
        localparam int SRC = ROW + 4 * ((COL + ROW) % 4);
        assign st_o[BLK_W-1-BYTE_W*i -: BYTE_W] = sbox(st_i[BLK_W-1-BYTE_W*SRC -: BYTE_W]);
    end
endmodule

// File: rtl/aes_mix_cols.sv
module aes_mix_cols
    import aes_rnd_pkg::*;
(
    input  logic [BLK_W-1:0] st_i,
    output logic [BLK_W-1:0] st_o
);
    localparam int COL_W = 4 * BYTE_W;

    for (genvar c = 0; c < 4; c++) begin : g_col
        logic [7:0] a0, a1, a2, a3;
        assign a0 = st_i[BLK_W-1-COL_W*c      -: BYTE_W];
        assign a1 = st_i[BLK_W-1-COL_W*c - 8  -: BYTE_W];
        assign a2 = st_i[BLK_W-1-COL_W*c - 16 -: BYTE_W];
        assign a3 = st_i[BLK_W-1-COL_W*c - 24 -: BYTE_W];
        assign st_o[BLK_W-1-COL_W*c      -: BYTE_W] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
        assign st_o[BLK_W-1-COL_W*c - 8  -: BYTE_W] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
        assign st_o[BLK_W-1-COL_W*c - 16 -: BYTE_W] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
        assign st_o[BLK_W-1-COL_W*c - 24 -: BYTE_W] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
endmodule

// File: rtl/aes256_round_engine.sv
module aes256_round_engine
    import aes_rnd_pkg::*;
#(
    parameter  int NR = 14,
    localparam int RW = $clog2(NR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] pt_i,
    input  logic [BLK_W-1:0] rk_i,
    output logic [RW-1:0]    rk_idx_o,
    output logic [BLK_W-1:0] ct_o,
    output logic             done_o
);
    localparam logic [RW-1:0] LAST = RW'(NR);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [RW-1:0]    rnd;
        logic [BLK_W-1:0] st;
    } eng_t;

    eng_t cur_q, nxt_d;
    logic [BLK_W-1:0] shifted_d, mixed_d, round_d;

    aes_sub_shift u_sub_shift (.st_i(cur_q.st), .st_o(shifted_d));
    aes_mix_cols  u_mix_cols  (.st_i(shifted_d), .st_o(mixed_d));

    always_comb begin
        round_d    = (cur_q.rnd == LAST) ? shifted_d : mixed_d;
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        if (!cur_q.busy) begin
            if (start_i) begin
                nxt_d.busy = 1'b1;
                nxt_d.rnd  = RW'(1);
                nxt_d.st   = pt_i ^ rk_i;
            end
        end else begin
            nxt_d.st = round_d ^ rk_i;
            if (cur_q.rnd == LAST) begin
                nxt_d.busy = 1'b0;
                nxt_d.done = 1'b1;
                nxt_d.rnd  = '0;
            end else begin
                nxt_d.rnd = cur_q.rnd + RW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rk_idx_o = cur_q.rnd;
    assign ct_o     = cur_q.st;
    assign done_o   = cur_q.done;

    assert_idle_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.busy |-> (rk_idx_o == '0));
    assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.busy && cur_q.rnd != LAST) |=> (cur_q.busy && rk_idx_o == $past(rk_idx_o) + RW'(1)));
    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.busy && cur_q.rnd == LAST) |=> (done_o && !cur_q.busy));
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.busy && start_i) |=> (rk_idx_o != RW'(1)));
    assert_done_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (cur_q.busy && rk_idx_o == RW'(1)));
endmodule

// File: tb/tb_aes256_round_engine.sv
module tb_aes256_round_engine;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [127:0] pt_i;
    logic [127:0] rk_i;
    logic [3:0]   rk_idx_o;
    logic [127:0] ct_o;
    logic         done_o;

    logic [127:0] rks [0:14];
    logic [7:0]   sb  [0:255];
    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    assign rk_i = rks[rk_idx_o];

    aes256_round_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pt_i(pt_i), .rk_i(rk_i),
        .rk_idx_o(rk_idx_o), .ct_o(ct_o), .done_o(done_o)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL R4 watchdog: actual %0d cycles, expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = 16'h0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] s;
            for (int y = 1; y < 256; y++) if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
            sb[x] = s;
        end
    endtask

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    task automatic set_keys(input logic [255:0] key);
        logic [31:0] w [0:59];
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 8; i++) w[i] = key[255-32*i -: 32];
        for (int i = 8; i < 60; i++) begin
            logic [31:0] t = w[i-1];
            if (i % 8 == 0) begin
                t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = gm(rc, 8'h02);
            end else if (i % 8 == 4) t = subw(t);
            w[i] = w[i-8] ^ t;
        end
        for (int k = 0; k < 15; k++) rks[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    endtask

    // Reference: column-major byte state, byte 0 in the top bits (R3, R6)
    function automatic logic [127:0] ref_enc(input logic [127:0] pt);
        logic [7:0] s [16];
        logic [7:0] u [16];
        logic [127:0] o;
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rks[0][127-8*i -: 8];
        for (int r = 1; r <= 14; r++) begin
            for (int row = 0; row < 4; row++)
                for (int c = 0; c < 4; c++) u[row+4*c] = sb[s[row+4*((c+row)%4)]];
            for (int c = 0; c < 4; c++) begin
                if (r < 14) begin
                    for (int row = 0; row < 4; row++)
                        s[row+4*c] = gm(u[row+4*c], 8'h02) ^ gm(u[(row+1)%4+4*c], 8'h03)
                                   ^ u[(row+2)%4+4*c] ^ u[(row+3)%4+4*c];
                end else begin
                    for (int row = 0; row < 4; row++) s[row+4*c] = u[row+4*c];
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ rks[r][127-8*i -: 8];
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
        return o;
    endfunction

    // Called at a negedge; returns at the negedge where done is expected.
    task automatic run_block(input logic [255:0] key, input logic [127:0] pt, input bit noisy);
        logic [127:0] exp;
        bit seq_ok = 1'b1;
        bit early  = 1'b0;
        set_keys(key);
        exp = ref_enc(pt);
        pt_i = pt;
        start_i = 1'b1;
        @(negedge clk);
        for (int n = 1; n < 15; n++) begin
            if (rk_idx_o != 4'(n)) seq_ok = 1'b0;
            if (done_o) early = 1'b1;
            if (noisy) begin
                start_i = 1'($urandom % 2);
                pt_i = {$urandom, $urandom, $urandom, $urandom};
            end else start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R2 index sequence 1..14", {127'h0, seq_ok}, 128'h1);
        chk("R4 done low before 15th cycle", {127'h0, early}, 128'h0);
        chk("R4 done in 15th cycle", {127'h0, done_o}, 128'h1);
        chk("R1 index zero at done", {124'h0, rk_idx_o}, 128'h0);
        chk(noisy ? "R5 ciphertext under busy noise" : "R3 R6 ciphertext", ct_o, exp);
    endtask

    initial begin
        logic [255:0] kat_key = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
        logic [127:0] kat_pt  = 128'h00112233445566778899aabbccddeeff;
        logic [127:0] kat_ct  = 128'h8ea2b7ca516745bfeafc49904b496089;
        logic [127:0] held;
        rst_n = 1'b0; start_i = 1'b0; pt_i = '0;
        for (int k = 0; k < 15; k++) rks[k] = '0;
        build_sbox();
        chk("R3 bench sbox 00", {120'h0, sb[0]}, 128'h63);
        chk("R3 bench sbox 53", {120'h0, sb[8'h53]}, 128'hed);
        repeat (3) @(negedge clk);
        chk("R1 done in reset", {127'h0, done_o}, 128'h0);
        chk("R1 index in reset", {124'h0, rk_idx_o}, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", {127'h0, done_o}, 128'h0);
        chk("R1 index after reset", {124'h0, rk_idx_o}, 128'h0);

        run_block(kat_key, kat_pt, 1'b0);
        chk("R8 known-answer ciphertext", ct_o, kat_ct);
        held = ct_o;
        @(negedge clk);
        chk("R4 done one cycle only", {127'h0, done_o}, 128'h0);
        chk("R4 ciphertext held", ct_o, held);
        @(negedge clk);

        run_block(kat_key, kat_pt, 1'b1);
        chk("R5 R8 noisy known-answer", ct_o, kat_ct);
        @(negedge clk);

        run_block('0, '0, 1'b0);
        run_block({256{1'b1}}, {128{1'b1}}, 1'b0);   // R7 back to back
        @(negedge clk);
        chk("R4 done low after chained pair", {127'h0, done_o}, 128'h0);

        for (int b = 0; b < 16; b++) begin
            logic [255:0] key = {$urandom, $urandom, $urandom, $urandom,
                                 $urandom, $urandom, $urandom, $urandom};
            logic [127:0] pt = {$urandom, $urandom, $urandom, $urandom};
            run_block(key, pt, b[0]);                // R7 chained when no gap
            if (b % 3 == 2) begin
                @(negedge clk);
                chk("R4 done low in gap", {127'h0, done_o}, 128'h0);
            end
        end
        @(negedge clk);
        summary();
        $finish;
    end
endmodule